// File: doc/BRIEF.md
# Threshold Alert Responder with Alert-Response Arbitration

This block sits beside the two-wire target of a device that compares a signed measurement against two limits. While interrupt mode is selected, a measurement at or above the upper limit, or below the lower limit, latches an alert and a cause flag. The latched alert pulls an open-drain, active-low alert line. A separate register-read path can clear the latch.

The block also watches the serial bus for the alert-response command byte. While its alert is latched it acknowledges that byte. It then transmits its own 7-bit target address followed by the cause flag as the least significant bit. Other alerting devices may answer on the same wired-AND data line, so the block compares each released bit against the line. If the line reads low when the block released it, the block has lost arbitration and falls silent for the rest of the byte. Only a device that sends its whole byte without losing clears its latch, and it does so when the master's acknowledge clock ends.

Top module: `smb_alert_resp`

## Requirements
- R1: With `int_mode` high, a valid sample whose signed value is greater than or equal to `lim_hi` sets the alert latch and sets the cause flag to 1. `alert_pull` reads 1 on the cycle after the sample.
- R2: With `int_mode` high, a valid sample below `lim_lo` (and not at or above `lim_hi`) sets the latch with cause 0. A sample with `lim_lo <= value < lim_hi` changes neither the latch nor the cause. A value equal to `lim_lo` does not alert.
- R3: While `int_mode` is low, samples are ignored and the latch is held clear. Dropping `int_mode` releases `alert_pull` on the next cycle.
- R4: After reset, `alert_pull` and `sda_pull` are 0. A latched alert stays set until a won alert response or a `rd_clear` pulse clears it, and a new threshold event in the same cycle takes priority over a clear.
- R5: The command byte 0x19 (address 0001100, read bit 1), sent MSB first after a START, is acknowledged by pulling SDA low during the ninth clock. This happens only when the alert is latched at the end of the eighth bit. Any other byte, or the command with no alert latched, is not acknowledged and leaves SDA released.
- R6: After the acknowledge, the block sends `{own_addr, cause}` MSB first. Each bit is placed after an SCL falling edge: a 0 pulls SDA low and a 1 releases it.
- R7: If the block releases SDA for a 1 and samples SDA low while SCL is high, it has lost arbitration and does not pull SDA for the remaining bits of the byte. The byte the master reads is then the wired-AND winner's byte.
- R8: When the whole byte is sent without loss, the alert latch clears at the SCL falling edge that ends the master's acknowledge bit. After a lost arbitration the alert stays set.
- R9: A START at any point restarts command reception. A STOP returns the block to idle with SDA released on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 pulls SDA low (open drain) |
| alert_pull | output | 1 | 1 pulls the active-low alert line low |
| int_mode | input | 1 | 1 selects interrupt mode |
| smp_valid | input | 1 | New measurement strobe |
| smp_value | input | VW | Signed measurement |
| lim_hi | input | VW | Signed upper limit |
| lim_lo | input | VW | Signed lower limit |
| rd_clear | input | 1 | Pulse from a register read that clears the alert |
| own_addr | input | AW | This device's 7-bit target address |

## Verification
The alert latch is one register away from the sample strobe. The bench therefore checks `alert_pull` at the falling clock edge that follows the strobe's capturing edge. Bus responses pass through a two-stage synchronizer, an edge register and the output register, so they are due about four clocks after an SCL edge. The emulated master holds each SCL phase for ten clocks and samples SDA one clock before it lowers SCL, well after the block has settled. A second responder modelled in the bench drives the line during the address byte to create arbitration. Each clear-or-keep outcome is read from `alert_pull` only after the following STOP.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_ADDR,
    RS_ACK,
    RS_SEND,
    RS_MACK
  } resp_state_t;
endpackage

// File: rtl/sar_bus_sense.sv
module sar_bus_sense #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC-1:0] scl_sr, sda_sr;
  logic scl_prev, sda_prev, scl_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr   <= '1;
      sda_sr   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sr   <= {scl_sr[SYNC-2:0], scl_in};
      sda_sr   <= {sda_sr[SYNC-2:0], sda_in};
      scl_prev <= scl_sr[SYNC-1];
      sda_prev <= sda_sr[SYNC-1];
    end
  end

  assign scl_now   = scl_sr[SYNC-1];
  assign sda_lvl   = sda_sr[SYNC-1];
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/sar_alert_latch.sv
module sar_alert_latch #(
  parameter int VW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 int_mode,
  input  logic                 smp_valid,
  input  logic signed [VW-1:0] smp_val,
  input  logic signed [VW-1:0] lim_hi,
  input  logic signed [VW-1:0] lim_lo,
  input  logic                 clr_win,
  input  logic                 clr_read,
  output logic                 alert_q,
  output logic                 cause_q
);
  logic hit_hi, hit_lo, set_evt;

  assign hit_hi  = smp_val >= lim_hi;
  assign hit_lo  = smp_val < lim_lo;
  assign set_evt = int_mode & smp_valid & (hit_hi | hit_lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      alert_q <= 1'b0;
      cause_q <= 1'b0;
    end else if (!int_mode) begin
      alert_q <= 1'b0;
    end else if (set_evt) begin
      alert_q <= 1'b1;
      cause_q <= hit_hi;
    end else if (clr_win || clr_read) begin
      alert_q <= 1'b0;
    end
  end

  p_hi_sets_r1: assert property (@(posedge clk) disable iff (rst)
    (int_mode && smp_valid && (smp_val >= lim_hi)) |=> (alert_q && cause_q));
  p_lo_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (int_mode && smp_valid && (smp_val < lim_lo) && !(smp_val >= lim_hi)) |=> (alert_q && !cause_q));
  p_mode_off_r3: assert property (@(posedge clk) disable iff (rst)
    !int_mode |=> !alert_q);
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    ((clr_win || clr_read) && !(smp_valid && ((smp_val >= lim_hi) || (smp_val < lim_lo)))) |=> !alert_q);
endmodule

// File: rtl/sar_responder.sv
module sar_responder
  import smb_alert_pkg::*;
#(
  parameter int          AW  = 7,
  parameter logic [7:0]  CMD = 8'h19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          alert_act,
  input  logic          cause,
  input  logic [AW-1:0] own_addr,
  output logic          sda_oe,
  output logic          win_pulse
);
  localparam int BW = AW + 1;
  localparam int CW = $clog2(BW + 1);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);
  localparam logic [CW-1:0] FULL = CW'(BW);

  resp_state_t   state_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] sh_q;
  logic          lost_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= RS_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      sda_oe    <= 1'b0;
      lost_q    <= 1'b0;
      win_pulse <= 1'b0;
    end else begin
      win_pulse <= 1'b0;
      if (stop_det) begin
        state_q <= RS_IDLE;
        sda_oe  <= 1'b0;
        lost_q  <= 1'b0;
      end else if (start_det) begin
        state_q <= RS_ADDR;
        cnt_q   <= '0;
        sda_oe  <= 1'b0;
        lost_q  <= 1'b0;
      end else begin
        case (state_q)
          RS_ADDR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[BW-2:0], sda_lvl};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == FULL) begin
              if (sh_q == CMD && alert_act) begin
                state_q <= RS_ACK;
                sda_oe  <= 1'b1;
              end else begin
                state_q <= RS_IDLE;
              end
            end
          end
          RS_ACK: begin
            if (scl_fall) begin
              state_q <= RS_SEND;
              sh_q    <= {own_addr, cause};
              sda_oe  <= ~own_addr[AW-1];
              cnt_q   <= '0;
              lost_q  <= 1'b0;
            end
          end
          RS_SEND: begin
            if (scl_rise) begin
              if (!lost_q && sh_q[BW-1] && !sda_lvl) lost_q <= 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == LAST) begin
                state_q <= RS_MACK;
                sda_oe  <= 1'b0;
              end else begin
                sh_q   <= {sh_q[BW-2:0], 1'b0};
                cnt_q  <= cnt_q + 1'b1;
                sda_oe <= ~lost_q & ~sh_q[BW-2];
              end
            end
          end
          RS_MACK: begin
            if (scl_fall) begin
              state_q   <= RS_IDLE;
              win_pulse <= ~lost_q;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_ack_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == RS_ACK && $past(state_q) != RS_ACK) |-> $past(alert_act));
  p_lost_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    lost_q |-> !sda_oe);
  p_win_clean_r8: assert property (@(posedge clk) disable iff (rst)
    win_pulse |-> $past(!lost_q));
  p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
endmodule

// File: rtl/smb_alert_resp.sv
module smb_alert_resp #(
  parameter int         VW  = 12,
  parameter int         AW  = 7,
  parameter int         SYNC = 2,
  parameter logic [7:0] CMD = 8'h19
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 sda_pull,
  output logic                 alert_pull,
  input  logic                 int_mode,
  input  logic                 smp_valid,
  input  logic signed [VW-1:0] smp_value,
  input  logic signed [VW-1:0] lim_hi,
  input  logic signed [VW-1:0] lim_lo,
  input  logic                 rd_clear,
  input  logic [AW-1:0]        own_addr
);
  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic alert_q, cause_q, win_pulse;

  sar_bus_sense #(.SYNC(SYNC)) u_sense (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  sar_alert_latch #(.VW(VW)) u_latch (
    .clk(clk), .rst(rst), .int_mode(int_mode), .smp_valid(smp_valid),
    .smp_val(smp_value), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .clr_win(win_pulse), .clr_read(rd_clear),
    .alert_q(alert_q), .cause_q(cause_q)
  );

  sar_responder #(.AW(AW), .CMD(CMD)) u_resp (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .alert_act(alert_q), .cause(cause_q), .own_addr(own_addr),
    .sda_oe(sda_pull), .win_pulse(win_pulse)
  );

  assign alert_pull = alert_q;
endmodule

// File: tb/smb_alert_resp_test.sv
`timescale 1ns/1ps
module smb_alert_resp_test;
  localparam int H = 10;
  localparam logic [6:0] OWN = 7'h48;

  logic clk = 0, rst = 1;
  logic m_scl = 1, m_sda = 1, o_sda = 1;
  logic sda_pull, alert_pull;
  logic int_mode = 1, smp_valid = 0, rd_clear = 0;
  logic signed [11:0] smp_value = 0, lim_hi = 200, lim_lo = -50;
  logic line;
  int n_tests = 0, n_fail = 0;
  bit done = 0;
  bit exp_alert = 0, exp_cause = 0;

  always #2 clk = ~clk;
  assign line = m_sda & o_sda & ~sda_pull;

  smb_alert_resp uut (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(line),
    .sda_pull(sda_pull), .alert_pull(alert_pull), .int_mode(int_mode),
    .smp_valid(smp_valid), .smp_value(smp_value), .lim_hi(lim_hi),
    .lim_lo(lim_lo), .rd_clear(rd_clear), .own_addr(OWN)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic void model_sample(input int v);
    if (!int_mode) begin
      exp_alert = 0;
    end else if (v >= int'(lim_hi)) begin
      exp_alert = 1; exp_cause = 1;
    end else if (v < int'(lim_lo)) begin
      exp_alert = 1; exp_cause = 0;
    end
  endfunction

  task automatic sample(input int v);
    @(negedge clk);
    smp_value = 12'(v); smp_valid = 1;
    @(negedge clk);
    smp_valid = 0;
    model_sample(v);
  endtask

  task automatic m_start();
    m_sda = 1; waitc(H); m_scl = 1; waitc(H); m_sda = 0; waitc(H); m_scl = 0; waitc(H);
  endtask

  task automatic m_stop();
    m_sda = 0; waitc(H); m_scl = 1; waitc(H); m_sda = 1; waitc(H);
  endtask

  task automatic wr_bit(input bit b);
    m_sda = b; waitc(H); m_scl = 1; waitc(H); m_scl = 0;
  endtask

  task automatic rd_bit(output bit b);
    m_sda = 1; waitc(H); m_scl = 1; waitc(H - 1); b = line; waitc(1); m_scl = 0;
  endtask

  task automatic wr_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
  endtask

  task automatic rd_byte(input bit oth_en, input logic [7:0] oth, output logic [7:0] r);
    bit o_lost = 0;
    for (int i = 7; i >= 0; i--) begin
      o_sda = (oth_en && !o_lost) ? oth[i] : 1'b1;
      m_sda = 1; waitc(H); m_scl = 1; waitc(H - 1);
      r[i] = line;
      if (oth_en && !o_lost && oth[i] && !line) o_lost = 1;
      waitc(1); m_scl = 0;
    end
    o_sda = 1;
  endtask

  task automatic ara(input logic [7:0] cmd, input bit oth_en, input logic [7:0] oth,
                     output bit acked, output logic [7:0] r);
    bit a;
    m_start();
    wr_byte(cmd);
    rd_bit(a);
    acked = !a;
    r = 8'hFF;
    if (acked) begin
      rd_byte(oth_en, oth, r);
      wr_bit(1);
    end
    m_stop();
    waitc(4);
  endtask

  task automatic ara_check(input string tag, input bit oth_en, input logic [7:0] oth);
    bit acked;
    logic [7:0] r, ours, expb;
    ours = {OWN, exp_cause};
    ara(8'h19, oth_en, oth, acked, r);
    chk({tag, " R5 ack"}, acked, exp_alert);
    if (exp_alert) begin
      expb = (oth_en && oth < ours) ? oth : ours;
      chk({tag, " R6/R7 byte"}, r, expb);
      if (!oth_en || ours <= oth) exp_alert = 0;
    end
    chk({tag, " R8 alert after"}, alert_pull, exp_alert);
    chk({tag, " R9 sda released"}, sda_pull, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit acked;
    logic [7:0] r;
    int seed;
    seed = 1234;
    void'($urandom(seed));
    waitc(4); rst = 0; waitc(2);
    chk("R4 reset alert", alert_pull, 0);
    chk("R4 reset sda", sda_pull, 0);

    sample(100); waitc(1);
    chk("R2 in range no alert", alert_pull, 0);
    sample(200); waitc(1);
    chk("R1 equal hi alerts", alert_pull, 1);
    ara_check("R1 hi cause win", 0, 8'h00);

    sample(-50); waitc(1);
    chk("R2 equal lo no alert", alert_pull, 0);
    sample(-51); waitc(1);
    chk("R2 below lo alerts", alert_pull, 1);
    ara_check("R7 loss", 1, 8'h10);
    chk("R8 loss keeps alert", alert_pull, 1);

    ara(8'h91, 0, 8'h00, acked, r);
    chk("R5 other byte no ack", acked, 0);
    chk("R5 alert kept", alert_pull, 1);

    m_start(); wr_bit(1); wr_bit(1); wr_bit(0); wr_bit(1);
    ara_check("R9 restart", 0, 8'h00);

    sample(900); waitc(1);
    @(negedge clk) rd_clear = 1;
    @(negedge clk) rd_clear = 0; exp_alert = 0;
    chk("R4 read clear", alert_pull, 0);
    ara_check("R5 no alert nack", 0, 8'h00);

    sample(-300); waitc(3);
    chk("R4 latched holds", alert_pull, 1);
    @(negedge clk) int_mode = 0;
    @(negedge clk); exp_alert = 0;
    chk("R3 mode off clears", alert_pull, 0);
    sample(900); waitc(1);
    chk("R3 mode off ignores", alert_pull, 0);
    @(negedge clk) int_mode = 1;

    sample(-100);
    @(negedge clk) begin smp_value = 300; smp_valid = 1; rd_clear = 1; end
    @(negedge clk) begin smp_valid = 0; rd_clear = 0; end
    model_sample(300);
    chk("R4 set beats clear", alert_pull, 1);
    ara_check("R6 cause tracks latest", 1, 8'hFF);

    for (int k = 0; k < 30; k++) begin
      int v;
      bit oe;
      lim_lo = 12'(-int'($urandom_range(800)));
      lim_hi = 12'(1 + $urandom_range(799));
      v = int'($urandom_range(2047)) - 1024;
      sample(v); waitc(1);
      chk("R1/R2 random latch", alert_pull, exp_alert);
      oe = exp_alert && ($urandom_range(1) == 1);
      ara_check("R7/R8 random", oe, 8'($urandom_range(255)));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule